// File: doc/BRIEF.md
# Wraparound Burst Address Generator

This block supplies the address for a four-beat burst into a synchronous memory. A load strobe starts a burst: it captures a complete start address and samples an ordering select. After that, each active-low advance strobe moves the burst to the next beat. Only the two least significant address bits change during a burst. The bits above them stay at the captured value.

Two beat orderings are supported. In linear order the low bits count up from the start value and wrap after four beats. In interleaved order the low bits are the start value exclusive-ORed with the beat number. The ordering select only takes effect at a load, so changing it in the middle of a burst does nothing. While the load strobe is high, the start address goes straight to the output in that same cycle. This lets the memory array see the first address without waiting a cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset, with no load, `addr_o` is zero and the beat count is zero.
- R2: In any cycle where `ld_i` is 1, `addr_o` equals `start_addr_i` in that same cycle.
- R3: A load sets the beat count to zero. In the first cycle after a load, `addr_o` equals the loaded start address.
- R4: When `mode_i` was 0 at load (linear), the low two bits of `addr_o` are (start low bits + beat count) mod 4.
- R5: When `mode_i` was 1 at load (interleaved), the low two bits of `addr_o` are start low bits XOR beat count.
- R6: The beat count steps by one on a clock edge where `adv_n_i` is 0 and `ld_i` is 0. It holds when `adv_n_i` is 1.
- R7: After four advances the beat count wraps to zero, and `addr_o` is again the start address.
- R8: Between loads, `addr_o` bits above bit 1 stay equal to the captured start address bits.
- R9: Load takes priority over advance. If `ld_i` is 1, `adv_n_i` is ignored in that cycle and the beat count is zero afterwards.
- R10: `mode_i` is sampled only on a load edge. Changes while no load is present do not affect `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_i | input | 1 | Load strobe: capture start address and order, clear beat |
| adv_n_i | input | 1 | Advance strobe, active low |
| mode_i | input | 1 | Order select at load: 0 linear, 1 interleaved |
| start_addr_i | input | ADDR_W | Burst start address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The assertions assume that the strobes and the ordering select are known, non-X values at every rising edge once reset is released. They also assume reset is held for at least one edge before any load. The stimulus meets these conditions by holding reset for three edges, changing all inputs only on the falling edge, and never driving X. Within each burst the ordering select is deliberately flipped, so that the property tying the latched order to load cycles is exercised against an input that does change.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic              adv_n_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] beat_q;

  // Load wins over advance; the count wraps naturally at 2**BEAT_W.
  always_ff @(posedge clk) begin
    if (rst)           beat_q <= '0;
    else if (ld_i)     beat_q <= '0;
    else if (!adv_n_i) beat_q <= beat_q + ONE;
  end

  assign beat_o = beat_q;

  AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (beat_o == '0));                                        // R9
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && adv_n_i) |=> $stable(beat_o));                         // R6
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !adv_n_i) |=> (beat_o == $past(beat_o) + ONE));        // R7
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] lane_o
);
  logic [BEAT_W-1:0] lin_lane;
  logic [BEAT_W-1:0] ilv_lane;

  assign lin_lane = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_lane[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    if (order_i == ORDER_INTERLEAVE) lane_o = ilv_lane;
    else                             lane_o = lin_lane;
  end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] base_o,
  output order_e            order_o
);
  logic [ADDR_W-1:0] base_q;
  order_e            order_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      order_q <= ORDER_LINEAR;
    end else if (ld_i) begin
      base_q  <= start_addr_i;
      order_q <= order_e'(mode_i);
    end
  end

  assign base_o  = base_q;
  assign order_o = order_q;

  AST_ORDER_LATCHED: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> $stable(order_o));                                     // R10
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base;
  order_e            order;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lane;
  logic [ADDR_W-1:0] burst_addr;

  burst_start_reg #(.ADDR_W(ADDR_W)) i_start (
    .clk(clk), .rst(rst), .ld_i(ld_i), .mode_i(mode_i),
    .start_addr_i(start_addr_i), .base_o(base), .order_o(order)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) i_beat (
    .clk(clk), .rst(rst), .ld_i(ld_i), .adv_n_i(adv_n_i), .beat_o(beat)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) i_map (
    .start_i(base[BEAT_W-1:0]), .beat_i(beat), .order_i(order), .lane_o(lane)
  );

  assign burst_addr = {base[ADDR_W-1:BEAT_W], lane};
  // The start address bypasses the registers in its load cycle.
  assign addr_o = ld_i ? start_addr_i : burst_addr;

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (ld_i || addr_o == $past(start_addr_i)));               // R3
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> (ld_i || addr_o[ADDR_W-1:BEAT_W] ==
               $past(addr_o[ADDR_W-1:BEAT_W])));                     // R8
  AST_HI_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && adv_n_i) |=> (ld_i || $stable(addr_o)));               // R6

  initial begin
    assert (HI_W >= 1);
  end
endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int AW = 6;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld = 1'b0, adv_n = 1'b1, mode = 1'b0;
  logic [AW-1:0] sa = '0;
  logic [AW-1:0] addr;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .ld_i(ld), .adv_n_i(adv_n), .mode_i(mode),
    .start_addr_i(sa), .addr_o(addr)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [AW-1:0] e_base = '0;
  logic          e_mode = 1'b0;
  logic [BW-1:0] e_beat = '0;

  function automatic logic [AW-1:0] model_out();
    logic [BW-1:0] low;
    if (ld) return sa;
    low = e_mode ? (e_base[BW-1:0] ^ e_beat) : (e_base[BW-1:0] + e_beat);
    return {e_base[AW-1:BW], low};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic l, input logic a, input logic m,
                      input logic [AW-1:0] s, input string tag);
    @(negedge clk);
    ld = l; adv_n = a; mode = m; sa = s;
    #1 check(tag, addr, model_out());
    @(posedge clk);
    if (ld) begin
      e_base = sa; e_mode = mode; e_beat = '0;
    end else if (!adv_n) begin
      e_beat = e_beat + 1'b1;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1", addr, '0);
    // R6 hold right after reset: no advance, address stays zero
    step(1'b0, 1'b1, 1'b1, 6'h3f, "R1 R6");

    for (int s = 0; s < (1 << AW); s++) begin
      for (int m = 0; m < 2; m++) begin
        logic adv_ld;
        int   n_adv;
        logic prev_adv_n;
        adv_ld = s[0];
        // load cycle; with adv_n low this exercises R9
        step(1'b1, adv_ld, m[0], AW'(s), adv_ld ? "R2" : "R2 R9");
        n_adv = 0;
        prev_adv_n = 1'b1;
        for (int k = 0; k < 9; k++) begin
          logic a;
          string tag;
          a = ((s + k + m) % 3 == 0);
          if (k == 0)                      tag = "R3";
          else if (e_beat == '0 && n_adv > 0) tag = "R7";
          else if (prev_adv_n)             tag = "R6";
          else if (m == 1)                 tag = "R5 R10";
          else                             tag = "R4 R10";
          step(1'b0, a, ~m[0], 6'h00, tag);
          if (!a) n_adv++;
          prev_adv_n = a;
        end
      end
    end

    // R8: upper bits constant across a long run of advances
    step(1'b1, 1'b1, 1'b0, 6'h2d, "R8");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b1, 6'h12, "R8");
    // R9: reload in mid burst with advance asserted restarts at beat zero
    step(1'b1, 1'b0, 1'b1, 6'h16, "R9");
    step(1'b0, 1'b1, 1'b0, 6'h00, "R9");
    // R1: reset in mid burst returns output to zero
    step(1'b0, 1'b0, 1'b0, 6'h00, "R5");
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0; ld = 1'b0; adv_n = 1'b1;
    e_base = '0; e_mode = 1'b0; e_beat = '0;
    #1 check("R1", addr, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule